// File: doc/BRIEF.md
# AES-128 Round Key Sequencer

This block turns a 128-bit AES key into the eleven round keys that an AES-128 encryption needs, one word at a time. A start strobe loads the key, and the key itself is presented on the next cycle as round 0. Each later round key is then built from four new 32-bit words, one word per clock. A mux over the four words of the current round picks the old word to combine. A second mux picks the other XOR operand: the transformed last word for the first word of a round, or the word just produced for the other three. The round key, its index and a one-cycle valid strobe are registered outputs.

A cipher datapath takes each round key on its valid pulse, or reads it while it is held, since the key stays put between pulses. A new start at any time abandons the schedule in progress and begins again from the new key.

Top module: `aes128_keysched`

## Requirements
- R1: While reset is asserted and after its release, `rkey` is 0, `rnd` is 0 and `rkey_vld` is 0 until the first start.
- R2: A start sampled at a clock edge makes the outputs show, from that edge on, `rkey` equal to the sampled `key_in`, `rnd` = 0 and `rkey_vld` = 1.
- R3: Round r (1 to 10) is presented with `rnd` = r and a one-cycle `rkey_vld` pulse exactly 4·r cycles after round 0. `rkey_vld` is low on every other cycle of a run.
- R4: Words are big-endian: word 0 is `key_in[127:96]` and round key r is {w[4r], w[4r+1], w[4r+2], w[4r+3]}, most significant word first. w[4r] = w[4r−4] ⊕ SubWord(RotWord(w[4r−1])) ⊕ Rcon(r). For k = 1..3, w[4r+k] = w[4r+k−4] ⊕ w[4r+k−1]. RotWord rotates a word left by one byte.
- R5: Rcon(r) carries RC(r) in its most significant byte and zeros elsewhere. RC runs 01, 02, 04, 08, 10, 20, 40, 80, 1B, 36 for rounds 1 to 10, each value being the previous one doubled in GF(2^8) modulo 0x11B.
- R6: SubWord replaces every byte by the AES S-box value. That value is the GF(2^8) inverse (0 maps to 0) followed by the affine map b_i ⊕ b_(i+4) ⊕ b_(i+5) ⊕ b_(i+6) ⊕ b_(i+7) ⊕ c_i, with c = 0x63. The all-zero key gives round 1 key 62636363 62636363 62636363 62636363.
- R7: Between two valid pulses, `rkey` and `rnd` keep the values presented with the last pulse.
- R8: After round 10, `rkey_vld` stays low and `rkey`/`rnd` hold round 10 until the next start.
- R9: A start during a run restarts at once with the new key's round 0. This holds even when the start falls on the edge at which a round would complete; the start wins and the old run leaves no trace.
- R10: Key 2b7e151628aed2a6abf7158809cf4f3c yields round 10 key d014f9a8c9ee2589e13f0cc8b6630ca6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Load `key_in` and begin a new schedule |
| key_in | input | 128 | Cipher key, sampled with `start` |
| rkey | output | 128 | Current round key |
| rnd | output | 4 | Index of the round key on `rkey` |
| rkey_vld | output | 1 | One-cycle pulse when a new round key appears |

## Verification
A start and the completion of a round can land on the same clock edge, because the fourth word of a round is written as the load of a new key is requested. The bench provokes this by issuing a second start exactly four cycles after the first. It then requires that the cycle after shows the second key as round 0, not round 1 of the first key. It also requires that the following forty cycles follow the second key's schedule alone. A start in the middle of a round, and the idle state after round 10, are judged against the same schedule, which the bench computes independently.

// File: rtl/aes128_keysched.sv
module aes128_keysched #(
  parameter int NR = 10,
  localparam int RW = $clog2(NR + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [127:0]  key_in,
  output logic [127:0]  rkey,
  output logic [RW-1:0] rnd,
  output logic          rkey_vld
);

  function automatic logic [7:0] xt(input logic [7:0] b);
    return {b[6:0], 1'b0} ^ (b[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p, x;
    p = 8'h00;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ x;
      x = xt(x);
    end
    return p;
  endfunction

  function automatic logic [7:0] sbox(input logic [7:0] a);
    logic [7:0] sq, r;
    sq = a;
    r  = 8'h01;
    for (int i = 1; i < 8; i++) begin
      sq = gmul(sq, sq);
      r  = gmul(r, sq);
    end
    return r ^ {r[6:0], r[7]} ^ {r[5:0], r[7:6]} ^ {r[4:0], r[7:5]} ^ {r[3:0], r[7:4]} ^ 8'h63;
  endfunction

  logic [2:0][31:0] part;
  logic [31:0]      prev;
  logic [1:0]       ph;
  logic [7:0]       rcon;
  logic             busy;

  logic [31:0] rot, gword, pick, opnd, neww;

  assign rot   = {rkey[23:0], rkey[31:24]};
  assign gword = {sbox(rot[31:24]) ^ rcon, sbox(rot[23:16]), sbox(rot[15:8]), sbox(rot[7:0])};
  assign opnd  = (ph == 2'd0) ? gword : prev;
  assign neww  = pick ^ opnd;

  always_comb begin
    case (ph)
      2'd0:    pick = rkey[127:96];
      2'd1:    pick = rkey[95:64];
      2'd2:    pick = rkey[63:32];
      default: pick = rkey[31:0];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rkey     <= '0;
      rnd      <= '0;
      rkey_vld <= 1'b0;
      part     <= '0;
      prev     <= '0;
      ph       <= 2'd0;
      rcon     <= 8'h01;
      busy     <= 1'b0;
    end else begin
      rkey_vld <= 1'b0;
      if (start) begin
        rkey     <= key_in;
        rnd      <= '0;
        rkey_vld <= 1'b1;
        ph       <= 2'd0;
        rcon     <= 8'h01;
        busy     <= 1'b1;
      end else if (busy) begin
        prev <= neww;
        ph   <= ph + 2'd1;
        if (ph != 2'd3) begin
          part[ph] <= neww;
        end else begin
          rkey     <= {part[0], part[1], part[2], neww};
          rnd      <= rnd + RW'(1);
          rkey_vld <= 1'b1;
          rcon     <= xt(rcon);
          if (rnd == RW'(NR - 1)) busy <= 1'b0;
        end
      end
    end
  end

endmodule

module aes128_keysched_chk #(
  parameter int NR = 10,
  localparam int RW = $clog2(NR + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [127:0]  key_in,
  input logic [127:0]  rkey,
  input logic [RW-1:0] rnd,
  input logic          rkey_vld
);

  // R2
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (rkey_vld && rnd == '0 && rkey == $past(key_in)));

  // R3
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rkey_vld && !start) |=> !rkey_vld);

  // R3
  rnd_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rkey_vld |-> (rnd <= RW'(NR)));

  // R7
  hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rkey_vld |-> ($stable(rkey) && $stable(rnd)));

  // R8
  final_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rnd == RW'(NR) && !start) |=> !rkey_vld);

endmodule

bind aes128_keysched aes128_keysched_chk #(.NR(NR)) chk_i (.*);

// File: tb/aes128_keysched_tb.sv
`timescale 1ns/1ps
module aes128_keysched_tb_top;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [127:0] key_in = '0;
  logic [127:0] rkey;
  logic [3:0]   rnd;
  logic         rkey_vld;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  logic [127:0] exp_rk [0:10];
  logic [127:0] got_rk [0:10];

  always #10 clk = ~clk;

  aes128_keysched dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .key_in(key_in),
    .rkey(rkey), .rnd(rnd), .rkey_vld(rkey_vld)
  );

  function automatic logic [7:0] bmul(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] acc = '0;
    for (int i = 0; i < 8; i++) if (b[i]) acc = acc ^ (16'(a) << i);
    for (int i = 15; i >= 8; i--) if (acc[i]) acc = acc ^ (16'h011b << (i - 8));
    return acc[7:0];
  endfunction

  function automatic logic [7:0] bsub(input logic [7:0] a);
    logic [7:0] v = 8'h00;
    logic [7:0] c = 8'h63;
    logic [7:0] o;
    for (int y = 1; y < 256; y++) if (bmul(a, 8'(y)) == 8'h01) v = 8'(y);
    for (int i = 0; i < 8; i++)
      o[i] = v[i] ^ v[(i+4)%8] ^ v[(i+5)%8] ^ v[(i+6)%8] ^ v[(i+7)%8] ^ c[i];
    return o;
  endfunction

  task automatic build(input logic [127:0] k);
    logic [31:0] w [0:43];
    logic [7:0]  rc = 8'h01;
    logic [31:0] t;
    for (int i = 0; i < 4; i++) w[i] = k[127-32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      t = w[i-1];
      if (i % 4 == 0) begin
        t = {t[23:0], t[31:24]};
        t = {bsub(t[31:24]) ^ rc, bsub(t[23:16]), bsub(t[15:8]), bsub(t[7:0])};
        rc = bmul(rc, 8'h02);
      end
      w[i] = w[i-4] ^ t;
    end
    for (int r = 0; r < 11; r++) exp_rk[r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
  endtask

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic launch(input logic [127:0] k);
    start = 1'b1;
    key_in = k;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic follow(input logic [127:0] k, input int n, input string tag0);
    int r;
    string tg;
    build(k);
    for (int c = 0; c < n; c++) begin
      if (c > 0) @(negedge clk);
      r = c / 4;
      if (c % 4 == 0) begin
        tg = (c == 0) ? tag0 : ((r >= 7) ? "R5" : "R4");
        chk(rkey_vld == 1'b1, "R3 vld", 128'(rkey_vld), 128'd1);
        chk(rnd == 4'(r), "R3 rnd", 128'(rnd), 128'(r));
        chk(rkey == exp_rk[r], tg, rkey, exp_rk[r]);
        got_rk[r] = rkey;
      end else begin
        chk(rkey_vld == 1'b0, "R3 gap", 128'(rkey_vld), 128'd0);
        chk(rkey == exp_rk[r] && rnd == 4'(r), "R7 hold", rkey, exp_rk[r]);
      end
    end
  endtask

  task automatic idle_check(input int n);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      chk(rkey_vld == 1'b0 && rnd == 4'd10, "R8 idle", {rnd, 3'b0, rkey_vld}, 128'ha0);
      chk(rkey == exp_rk[10], "R8 key", rkey, exp_rk[10]);
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [127:0] k;
    repeat (3) @(negedge clk);
    chk(rkey == '0 && rnd == 0 && rkey_vld == 0, "R1 in reset", rkey, 128'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(rkey == '0 && rnd == 0 && rkey_vld == 0, "R1 after reset", rkey, 128'd0);

    launch(128'h2b7e151628aed2a6abf7158809cf4f3c);
    follow(128'h2b7e151628aed2a6abf7158809cf4f3c, 41, "R2");
    chk(got_rk[10] == 128'hd014f9a8c9ee2589e13f0cc8b6630ca6, "R10 vector",
        got_rk[10], 128'hd014f9a8c9ee2589e13f0cc8b6630ca6);
    idle_check(6);

    launch('0);
    follow('0, 41, "R2");
    chk(got_rk[1] == {4{32'h62636363}}, "R6 zero key", got_rk[1], {4{32'h62636363}});
    idle_check(3);

    for (int i = 0; i < 10; i++) begin
      k = {4{32'h01020304 * (i + 1)}} ^ {32'(i) * 32'h9e3779b9, 96'hffffffff_00ff00ff_a5a5a5a5};
      if (i == 9) k = '1;
      launch(k);
      follow(k, 41, "R2");
      idle_check(2);
    end

    launch(128'h000102030405060708090a0b0c0d0e0f);
    follow(128'h000102030405060708090a0b0c0d0e0f, 4, "R2");
    launch(128'h3243f6a8885a308d313198a2e0370734);
    follow(128'h3243f6a8885a308d313198a2e0370734, 41, "R9 start on completion");
    idle_check(2);

    launch(128'hffeeddccbbaa99887766554433221100);
    follow(128'hffeeddccbbaa99887766554433221100, 6, "R2");
    launch(128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0);
    follow(128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0, 41, "R9 start mid round");
    idle_check(4);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule